// File: doc/BRIEF.md
# Forwarding and Load-Use Stall Unit

This block holds the hazard logic of a five-stage in-order integer pipeline. Each cycle it takes the two source register numbers of the instruction now in execute. It compares them with the destination numbers of the two older instructions, in the memory stage and in write-back. From that comparison it picks, for each ALU input, one of three sources: the register-file read value, the result held in the EX/MEM register, or the value held in the MEM/WB register. The memory-stage result is the youngest and wins when both stages match.

Forwarding cannot rescue a load followed directly by an instruction that consumes its result, because the loaded data only exists at the end of the load's memory cycle. The block spots that pairing while the load is in execute and the consumer is still in decode. It then asks the surrounding pipeline to keep the PC and the IF/ID register unchanged and to inject a bubble into ID/EX for one cycle. That bubble clears the load flag that ID/EX presents in the next cycle, so the stall lasts exactly one cycle and the consumer then receives the value through the write-back path. All outputs are combinational functions of the current stage fields.

Top module: `hazard_unit`

## Requirements
- R1: With no qualifying match in the memory or write-back stage, an operand select is 2'b00 (register file); the code 2'b11 is never produced.
- R2: When the EX/MEM destination equals an execute source, that destination is nonzero and its write enable is set, the select for that operand is 2'b10.
- R3: When only the MEM/WB destination qualifies (equal, nonzero, write enable set), the select for that operand is 2'b01, which covers a write-back in the same cycle as the read.
- R4: When both the EX/MEM and the MEM/WB destinations qualify for the same operand, the select is 2'b10.
- R5: A destination of register 0 never causes forwarding, even with its write enable set.
- R6: A stage whose write enable is clear never causes forwarding, even when its destination matches; a qualifying match in the other stage still applies.
- R7: When the ID/EX load flag is set and the ID/EX rt equals the IF/ID rs or rt, pc_hold, ifid_hold and idex_bubble are all 1. When the bubble has cleared the load flag in the next cycle, all three are 0 again. The comparison is made for every register number, 0 included.
- R8: With the load flag clear, or with no equality between ID/EX rt and either IF/ID source, pc_hold, ifid_hold and idex_bubble are all 0.
- R9: The two operand selects are decided independently, so rs and rt may take different sources in the same cycle, or the same source when they name the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ifid_rs | input | 5 | First source register of the instruction in decode |
| ifid_rt | input | 5 | Second source register of the instruction in decode |
| idex_rs | input | 5 | First source register of the instruction in execute |
| idex_rt | input | 5 | Second source register of the instruction in execute |
| idex_mem_read | input | 1 | Instruction in execute is a load |
| exmem_rd | input | 5 | Destination register of the instruction in the memory stage |
| exmem_reg_write | input | 1 | Instruction in the memory stage writes a register |
| memwb_rd | input | 5 | Destination register of the instruction in write-back |
| memwb_reg_write | input | 1 | Instruction in write-back writes a register |
| fwd_a_sel | output | 2 | ALU input A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_b_sel | output | 2 | ALU input B source, same encoding |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged this cycle |
| idex_bubble | output | 1 | Zero the ID/EX control bits this cycle |

## Verification
The block holds no state, so a wrong decision is visible on the select or stall outputs in the same cycle as the stage fields that provoke it. A broken priority or a missing zero-register or write-enable qualifier shows as a wrong select code for one operand, while the other operand stays correct. A wrong load-use comparison shows either as a missing stall, where the consumer would read stale data, or as a stall that is not needed and costs a cycle. The stall cases are checked in pairs: first the stall, then the cycle that follows the bubble, so that a stall lasting longer than one cycle would also be caught.

// File: rtl/hazard_pkg.sv
// Shared definitions for the forwarding and load-use stall logic.
// Assumes a register file in which register 0 is hard-wired to zero.
package hazard_pkg;
    localparam int SEL_W = 2;

    // Operand source codes; a pipeline mux decodes these bit patterns.
    typedef enum logic [SEL_W-1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/dest_match.sv
// Decides whether one older stage may supply one execute-stage source.
// A hit needs the stage to write a register, a nonzero destination and
// an equal register number. Purely combinational.
module dest_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_reg,
    input  logic [AW-1:0] dst_reg,
    input  logic          dst_wen,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    // Qualify the equality with write enable and the zero register.
    always_comb begin
        hit = dst_wen && (dst_reg != ZERO_REG) && (dst_reg == src_reg);
    end
endmodule

// File: rtl/operand_select.sv
// Picks the source of one ALU operand from the two older stages.
// The memory stage holds the younger result, so it outranks write-back.
// Assumes the register file itself supplies every other case.
module operand_select #(
    parameter int AW = 5
) (
    input  logic [AW-1:0]        src_reg,
    input  logic [AW-1:0]        exmem_rd,
    input  logic                 exmem_wen,
    input  logic [AW-1:0]        memwb_rd,
    input  logic                 memwb_wen,
    output hazard_pkg::fwd_src_e sel
);
    import hazard_pkg::*;

    logic hit_mem;
    logic hit_wb;

    dest_match #(.AW(AW)) u_mem_match (
        .src_reg (src_reg),
        .dst_reg (exmem_rd),
        .dst_wen (exmem_wen),
        .hit     (hit_mem)
    );

    dest_match #(.AW(AW)) u_wb_match (
        .src_reg (src_reg),
        .dst_reg (memwb_rd),
        .dst_wen (memwb_wen),
        .hit     (hit_wb)
    );

    // Priority choice: youngest producer first, register file last.
    always_comb begin
        if (hit_mem) begin
            sel = SRC_EXMEM;
        end else if (hit_wb) begin
            sel = SRC_MEMWB;
        end else begin
            sel = SRC_REGFILE;
        end
    end
endmodule

// File: rtl/load_use_detect.sv
// Flags a load in execute whose destination is read by the decode
// instruction. Assumes the load writes its rt field and that the bubble
// it requests clears the load flag one cycle later.
module load_use_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] dec_src,
    input  logic [AW-1:0]           load_dst,
    input  logic                    load_in_ex,
    output logic                    stall
);
    logic [NSRC-1:0] src_eq;

    // One comparator for each decode source field.
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign src_eq[g] = (dec_src[g] == load_dst);
    end

    // Stall only when a load is in execute and some source collides.
    always_comb begin
        stall = load_in_ex && (|src_eq);
    end
endmodule

// File: rtl/hazard_unit.sv
// Top of the forwarding and load-use stall logic of a five-stage pipeline.
// Produces two operand selects and the hold and bubble controls from the
// register fields of the decode, execute, memory and write-back stages.
// Assumes register writes complete at the clock edge that closes write-back.
module hazard_unit #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ifid_rs,
    input  logic [AW-1:0] ifid_rt,
    input  logic [AW-1:0] idex_rs,
    input  logic [AW-1:0] idex_rt,
    input  logic          idex_mem_read,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_reg_write,
    input  logic [AW-1:0] memwb_rd,
    input  logic          memwb_reg_write,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble
);
    import hazard_pkg::*;

    localparam int NOPND = 2;

    logic [NOPND-1:0][AW-1:0] ex_src;
    logic [NOPND-1:0][AW-1:0] dec_src;
    fwd_src_e                 sel [NOPND];
    logic                     lu_stall;

    // Gather the execute and decode source fields into arrays.
    always_comb begin
        ex_src[0]  = idex_rs;
        ex_src[1]  = idex_rt;
        dec_src[0] = ifid_rs;
        dec_src[1] = ifid_rt;
    end

    // One operand selector for each ALU input.
    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        operand_select #(.AW(AW)) u_sel (
            .src_reg   (ex_src[g]),
            .exmem_rd  (exmem_rd),
            .exmem_wen (exmem_reg_write),
            .memwb_rd  (memwb_rd),
            .memwb_wen (memwb_reg_write),
            .sel       (sel[g])
        );
    end

    load_use_detect #(.AW(AW), .NSRC(NOPND)) u_lu (
        .dec_src    (dec_src),
        .load_dst   (idex_rt),
        .load_in_ex (idex_mem_read),
        .stall      (lu_stall)
    );

    // Drive the ports from the selectors and the stall detector.
    always_comb begin
        fwd_a_sel   = sel[0];
        fwd_b_sel   = sel[1];
        pc_hold     = lu_stall;
        ifid_hold   = lu_stall;
        idex_bubble = lu_stall;
    end
endmodule

// File: rtl/hazard_unit_chk.sv
// Assertion checker for hazard_unit. The unit has no clock, so the
// checks are immediate assertions re-evaluated whenever a port changes.
module hazard_unit_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] ifid_rs,
    input logic [AW-1:0] ifid_rt,
    input logic [AW-1:0] idex_rs,
    input logic [AW-1:0] idex_rt,
    input logic          idex_mem_read,
    input logic [AW-1:0] exmem_rd,
    input logic          exmem_reg_write,
    input logic [AW-1:0] memwb_rd,
    input logic          memwb_reg_write,
    input logic [1:0]    fwd_a_sel,
    input logic [1:0]    fwd_b_sel,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          idex_bubble
);
    // Relate each output code back to the stage fields that justify it.
    always_comb begin
        // R1
        sel_code_legal_chk: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
            else $error("reserved select code produced");
        // R2
        a_exmem_src_chk: assert (fwd_a_sel != 2'b10 ||
                (exmem_reg_write && exmem_rd != '0 && exmem_rd == idex_rs))
            else $error("operand A took EX/MEM without a qualifying match");
        // R3
        a_memwb_src_chk: assert (fwd_a_sel != 2'b01 ||
                (memwb_reg_write && memwb_rd != '0 && memwb_rd == idex_rs))
            else $error("operand A took MEM/WB without a qualifying match");
        // R4
        b_priority_chk: assert (!(exmem_reg_write && exmem_rd != '0 &&
                exmem_rd == idex_rt) || fwd_b_sel == 2'b10)
            else $error("operand B lost a memory-stage match");
        // R7
        stall_agree_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
            else $error("hold and bubble controls disagree");
        // R8
        stall_needs_load_chk: assert (!pc_hold || idex_mem_read)
            else $error("stall raised without a load in execute");
    end
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_hazard_chk (.*);

// File: tb/test_hazard_unit.sv
// Self-checking bench for hazard_unit: a vector table walked by one loop,
// then directed checks for the idle state and the cycle after a stall.
module test_hazard_unit;
    typedef struct packed {
        logic [4:0] ifid_rs;
        logic [4:0] ifid_rt;
        logic [4:0] idex_rs;
        logic [4:0] idex_rt;
        logic       mr;
        logic [4:0] exmem_rd;
        logic       exmem_rw;
        logic [4:0] memwb_rd;
        logic       memwb_rw;
        logic [1:0] exp_a;
        logic [1:0] exp_b;
        logic       exp_stall;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        // R1: all fields idle
        '{5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0},
        // R2: back-to-back dependency on rs
        '{5'd1, 5'd2, 5'd3, 5'd1, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0},
        // R2: back-to-back dependency on rt
        '{5'd1, 5'd2, 5'd2, 5'd4, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 2'b00, 2'b10, 1'b0},
        // R3: distance-2 dependency on rs
        '{5'd1, 5'd2, 5'd5, 5'd1, 1'b0, 5'd9, 1'b1, 5'd5, 1'b1, 2'b01, 2'b00, 1'b0},
        // R4: both stages write the same register
        '{5'd1, 5'd2, 5'd6, 5'd1, 1'b0, 5'd6, 1'b1, 5'd6, 1'b1, 2'b10, 2'b00, 1'b0},
        // R5: writes to register 0 in both stages
        '{5'd1, 5'd2, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0},
        // R6: matches with write enables clear
        '{5'd1, 5'd2, 5'd7, 5'd7, 1'b0, 5'd7, 1'b0, 5'd7, 1'b0, 2'b00, 2'b00, 1'b0},
        // R6: memory stage disabled, write-back still forwards
        '{5'd1, 5'd2, 5'd8, 5'd1, 1'b0, 5'd8, 1'b0, 5'd8, 1'b1, 2'b01, 2'b00, 1'b0},
        // R7: load-use through decode rs
        '{5'd9, 5'd2, 5'd0, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1},
        // R7: load-use through decode rt
        '{5'd3, 5'd9, 5'd0, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1},
        // R8: same registers, no load
        '{5'd9, 5'd9, 5'd0, 5'd9, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0},
        // R8: load without a collision
        '{5'd1, 5'd2, 5'd0, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0},
        // R9: rs from memory stage, rt from write-back
        '{5'd1, 5'd2, 5'd10, 5'd11, 1'b0, 5'd10, 1'b1, 5'd11, 1'b1, 2'b10, 2'b01, 1'b0},
        // R9: rs equals rt, both from memory stage
        '{5'd1, 5'd2, 5'd12, 5'd12, 1'b0, 5'd12, 1'b1, 5'd3, 1'b1, 2'b10, 2'b10, 1'b0},
        // R1: distance 3, producer already retired, no in-flight match
        '{5'd1, 5'd2, 5'd13, 5'd1, 1'b0, 5'd14, 1'b1, 5'd15, 1'b1, 2'b00, 2'b00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd;
    logic       idex_mem_read, exmem_reg_write, memwb_reg_write;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       pc_hold, ifid_hold, idex_bubble;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    hazard_unit i_hazard_unit (
        .ifid_rs         (ifid_rs),
        .ifid_rt         (ifid_rt),
        .idex_rs         (idex_rs),
        .idex_rt         (idex_rt),
        .idex_mem_read   (idex_mem_read),
        .exmem_rd        (exmem_rd),
        .exmem_reg_write (exmem_reg_write),
        .memwb_rd        (memwb_rd),
        .memwb_reg_write (memwb_reg_write),
        .fwd_a_sel       (fwd_a_sel),
        .fwd_b_sel       (fwd_b_sel),
        .pc_hold         (pc_hold),
        .ifid_hold       (ifid_hold),
        .idex_bubble     (idex_bubble)
    );

    task automatic apply(input vec_t v);
        @(negedge clk);
        ifid_rs = v.ifid_rs;  ifid_rt = v.ifid_rt;
        idex_rs = v.idex_rs;  idex_rt = v.idex_rt;
        idex_mem_read = v.mr;
        exmem_rd = v.exmem_rd; exmem_reg_write = v.exmem_rw;
        memwb_rd = v.memwb_rd; memwb_reg_write = v.memwb_rw;
        #1;
    endtask

    task automatic check(input string req, input vec_t v);
        logic [2:0] act_st;
        act_st = {pc_hold, ifid_hold, idex_bubble};
        n_chk++;
        if (fwd_a_sel !== v.exp_a || fwd_b_sel !== v.exp_b ||
            act_st !== {3{v.exp_stall}}) begin
            n_bad++;
            $display("FAIL %s: a=%b b=%b stall=%b, expected a=%b b=%b stall=%b",
                     req, fwd_a_sel, fwd_b_sel, act_st,
                     v.exp_a, v.exp_b, {3{v.exp_stall}});
        end
    endtask

    initial begin
        vec_t v;
        v = '0;
        apply(v);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle state after reset
        apply(v);
        check("R1 idle", v);
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            check($sformatf("vector %0d", i), VECS[i]);
        end
        // R7: load-use stall, then the bubble clears the load flag
        v = '{5'd20, 5'd21, 5'd0, 5'd20, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0,
              2'b00, 2'b00, 1'b1};
        apply(v);
        check("R7 stall", v);
        v = '{5'd20, 5'd21, 5'd0, 5'd0, 1'b0, 5'd20, 1'b1, 5'd0, 1'b0,
              2'b00, 2'b00, 1'b0};
        apply(v);
        check("R7 after bubble", v);
        // R3: consumer released, load result now in write-back
        v = '{5'd1, 5'd2, 5'd20, 5'd21, 1'b0, 5'd0, 1'b0, 5'd20, 1'b1,
              2'b01, 2'b00, 1'b0};
        apply(v);
        check("R3 load via write-back", v);
        // R7: register 0 collision still stalls
        v = '{5'd0, 5'd4, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0,
              2'b00, 2'b00, 1'b1};
        apply(v);
        check("R7 zero register", v);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule